// File: doc/BRIEF.md
# Scanline Edge Coverage Mask Generator

This block turns triangle edge crossings into pixel coverage for a strip 32 pixels wide and 8 scanlines tall. Each of the eight scanlines has its own lane, and all lanes work in the same cycle. For every edge, each lane receives an integer crossing position. The position is measured in pixels from the left border of the strip. The lane starts from an all-ones word and shifts it to that position. A flag marks an edge as right-facing, and the shifted word is then complemented. The per-edge words of a lane are ANDed together, so that only pixels inside every enabled edge stay set.

The 256 coverage bits are then regrouped. Instead of eight scanline words, the output is eight tile words, each covering 8x4 pixels. A depth test can then work on one compact tile per word.

All edges of a triangle are presented together with a valid strobe. The tile masks appear in a register one clock later, and they hold their value until the next strobe. Up to three edges can be given, and each has its own enable.

Top module: `cov_strip_mask`

## Requirements
- R1: Every scanline lane uses only its own crossing positions, so different lanes of the same edge may carry different positions in the same cycle.
- R2: For an enabled edge with the right-facing flag at 0, pixel x of a scanline (bit x of that scanline's word, bit 0 = leftmost pixel) is covered exactly when x >= the lane's position.
- R3: For an enabled edge with the right-facing flag at 1, pixel x is covered exactly when x < the lane's position.
- R4: Positions are signed two's-complement. A position <= 0 gives an all-ones word for a left-facing edge and an all-zeros word for a right-facing edge. A position >= 32 gives all zeros for a left-facing edge and all ones for a right-facing edge.
- R5: An edge whose enable is 0 contributes all ones, so with no edge enabled every output bit is 1, whatever the positions are.
- R6: The coverage of a scanline is the bitwise AND of the words of all enabled edges.
- R7: Output tile k (k = 0..7) sits at bits [32k+31:32k]. Its byte r (bits [8r+7:8r], r = 0..3) is bits [8(k mod 4)+7 : 8(k mod 4)] of scanline 4*(k div 4)+r. Tiles 0 to 3 form the upper row and tiles 4 to 7 the lower row.
- R8: When the valid strobe is high in a cycle, the tile masks for that cycle's inputs are present and the output valid is high after the next rising clock edge. Without a strobe, the output valid is low and the tile masks keep their value.
- R9: While reset is asserted, the output valid is low and all tile mask bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | The edge data in this cycle is to be processed |
| edge_en | input | 3 | Enable per edge |
| edge_right | input | 3 | Per edge: 1 = right-facing (mask complemented) |
| edge_ofs | input | 168 | Signed 7-bit position for edge e, lane l at bits [(8e+l)*7 +: 7] |
| out_valid | output | 1 | Tile masks were updated on the last edge |
| tile_mask | output | 256 | Eight 32-bit tile masks, tile k at bits [32k +: 32] |

## Verification
A single-edge sweep runs every position from below 0 to beyond 32, in each edge slot and with both facings. This separates the left-facing and right-facing mask shapes and shows the clamping at both ends of the strip. Each lane gets a different position, so a lane mix-up or a scrambled tile byte shows up as a wrong bit position.

A grid of left/right edge pairs forms spans that are empty, narrow and wide, which exposes an OR in place of the AND. A set of pseudo-random three-edge triangles with random enables covers the mixed cases. Two further tests use all edges disabled, and an idle cycle carrying changed data, to show that disabled edges and unstrobed inputs leave no trace.

// File: rtl/cov_pkg.sv
package cov_pkg;

  localparam int unsigned DEF_EDGES  = 3;
  localparam int unsigned DEF_LANES  = 8;
  localparam int unsigned DEF_STRIPW = 32;
  localparam int unsigned DEF_TILEW  = 8;
  localparam int unsigned DEF_TILEH  = 4;

  // scanline that feeds byte row r of tile k
  function automatic int unsigned src_lane(input int unsigned k, input int unsigned r,
                                           input int unsigned per_row, input int unsigned th);
    return (k / per_row) * th + r;
  endfunction

  // first pixel column that feeds tile k
  function automatic int unsigned src_col(input int unsigned k, input int unsigned per_row,
                                          input int unsigned tw);
    return (k % per_row) * tw;
  endfunction

endpackage

// File: rtl/cov_edge_mask.sv
module cov_edge_mask #(
  parameter int unsigned STRIPW = 32,
  parameter int unsigned OFS_W  = 7
) (
  input  logic signed [OFS_W-1:0] ofs_i,
  input  logic                    en_i,
  input  logic                    right_i,
  output logic [STRIPW-1:0]       mask_o
);

  localparam int unsigned SH_W = $clog2(STRIPW);
  localparam logic signed [OFS_W-1:0] LIMIT = OFS_W'(STRIPW);

  logic [STRIPW-1:0] shifted;

  // all-ones word moved to the crossing, clamped at both strip borders
  always_comb begin
    if (ofs_i <= 0) begin
      shifted = '1;
    end else if (ofs_i >= LIMIT) begin
      shifted = '0;
    end else begin
      shifted = {STRIPW{1'b1}} << ofs_i[SH_W-1:0];
    end
  end

  always_comb begin
    if (!en_i) begin
      mask_o = '1;
    end else if (right_i) begin
      mask_o = ~shifted;
    end else begin
      mask_o = shifted;
    end
  end

endmodule

// File: rtl/cov_lane_and.sv
module cov_lane_and #(
  parameter int unsigned EDGES  = 3,
  parameter int unsigned STRIPW = 32
) (
  input  logic [EDGES*STRIPW-1:0] edge_masks_i,
  output logic [STRIPW-1:0]       lane_mask_o
);

  always_comb begin
    lane_mask_o = '1;
    for (int e = 0; e < EDGES; e++) begin
      lane_mask_o = lane_mask_o & edge_masks_i[e*STRIPW +: STRIPW];
    end
  end

endmodule

// File: rtl/cov_tile_shuffle.sv
module cov_tile_shuffle
  import cov_pkg::*;
#(
  parameter int unsigned LANES  = 8,
  parameter int unsigned STRIPW = 32,
  parameter int unsigned TILEW  = 8,
  parameter int unsigned TILEH  = 4
) (
  input  logic [LANES*STRIPW-1:0] lanes_i,
  output logic [LANES*STRIPW-1:0] tiles_o
);

  localparam int unsigned PER_ROW = STRIPW / TILEW;
  localparam int unsigned TILES   = PER_ROW * (LANES / TILEH);
  localparam int unsigned TBITS   = TILEW * TILEH;

  for (genvar k = 0; k < TILES; k++) begin : g_tile
    for (genvar r = 0; r < TILEH; r++) begin : g_row
      localparam int unsigned SL = src_lane(k, r, PER_ROW, TILEH);
      localparam int unsigned SC = src_col(k, PER_ROW, TILEW);
      assign tiles_o[k*TBITS + r*TILEW +: TILEW] = lanes_i[SL*STRIPW + SC +: TILEW];
    end
  end

endmodule

// File: rtl/cov_strip_mask.sv
module cov_strip_mask
  import cov_pkg::*;
#(
  parameter int unsigned EDGES  = DEF_EDGES,
  parameter int unsigned LANES  = DEF_LANES,
  parameter int unsigned STRIPW = DEF_STRIPW,
  parameter int unsigned TILEW  = DEF_TILEW,
  parameter int unsigned TILEH  = DEF_TILEH,
  parameter int unsigned OFS_W  = $clog2(DEF_STRIPW) + 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          in_valid,
  input  logic [EDGES-1:0]              edge_en,
  input  logic [EDGES-1:0]              edge_right,
  input  logic [EDGES*LANES*OFS_W-1:0]  edge_ofs,
  output logic                          out_valid,
  output logic [LANES*STRIPW-1:0]       tile_mask
);

  localparam int unsigned ALLBITS = LANES * STRIPW;
  localparam logic signed [OFS_W-1:0] LIMIT = OFS_W'(STRIPW);

  logic [ALLBITS-1:0] lane_all;
  logic [ALLBITS-1:0] tiles_c;
  logic [ALLBITS-1:0] tile_d, tile_q;
  logic               vld_d, vld_q;
  logic signed [OFS_W-1:0] ofs_a [EDGES][LANES];

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [EDGES*STRIPW-1:0] em;
    for (genvar e = 0; e < EDGES; e++) begin : g_edge
      assign ofs_a[e][l] = edge_ofs[(e*LANES + l)*OFS_W +: OFS_W];
      cov_edge_mask #(.STRIPW(STRIPW), .OFS_W(OFS_W)) u_edge (
        .ofs_i   (ofs_a[e][l]),
        .en_i    (edge_en[e]),
        .right_i (edge_right[e]),
        .mask_o  (em[e*STRIPW +: STRIPW])
      );

      AST_LEFT_PAST_END: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && edge_en[e] && !edge_right[e] && (ofs_a[e][l] >= LIMIT))
          |-> (lane_all[l*STRIPW +: STRIPW] == '0)); // R4
      AST_RIGHT_BEFORE_START: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && edge_en[e] && edge_right[e] && (ofs_a[e][l] <= 0))
          |-> (lane_all[l*STRIPW +: STRIPW] == '0)); // R4
    end
    cov_lane_and #(.EDGES(EDGES), .STRIPW(STRIPW)) u_and (
      .edge_masks_i (em),
      .lane_mask_o  (lane_all[l*STRIPW +: STRIPW])
    );
  end

  cov_tile_shuffle #(.LANES(LANES), .STRIPW(STRIPW), .TILEW(TILEW), .TILEH(TILEH)) u_shuf (
    .lanes_i (lane_all),
    .tiles_o (tiles_c)
  );

  // next state: capture on strobe, otherwise hold
  always_comb begin
    vld_d  = in_valid;
    tile_d = in_valid ? tiles_c : tile_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      tile_q <= '0;
    end else begin
      vld_q  <= vld_d;
      tile_q <= tile_d;
    end
  end

  assign out_valid = vld_q;
  assign tile_mask = tile_q;

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R8
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(tile_mask))); // R8
  AST_NO_EDGE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (edge_en == '0)) |=> (&tile_mask)); // R5
  AST_SHUFFLE_KEEPS_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> ($countones(tile_mask) == $past($countones(lane_all)))); // R7

endmodule

// File: tb/tb_cov_strip_mask.sv
`timescale 1ns/1ps
module tb_cov_strip_mask;

  localparam int NE = 3;
  localparam int NL = 8;
  localparam int W  = 32;
  localparam int OW = 7;
  localparam int NB = NL * W;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              in_valid;
  logic [NE-1:0]     edge_en;
  logic [NE-1:0]     edge_right;
  logic [NE*NL*OW-1:0] edge_ofs;
  logic              out_valid;
  logic [NB-1:0]     tile_mask;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  int ofs_t [NE][NL];
  bit en_t  [NE];
  bit rt_t  [NE];
  logic [NB-1:0] last_exp;

  always #10 clk = ~clk;

  cov_strip_mask dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .edge_en(edge_en),
    .edge_right(edge_right), .edge_ofs(edge_ofs), .out_valid(out_valid),
    .tile_mask(tile_mask)
  );

  function automatic logic [NB-1:0] model();
    logic [W-1:0] ln [NL];
    logic [NB-1:0] t;
    for (int l = 0; l < NL; l++) begin
      for (int x = 0; x < W; x++) begin
        bit c = 1'b1;
        for (int e = 0; e < NE; e++) begin
          if (en_t[e]) begin
            if (rt_t[e]) c = c & (x < ofs_t[e][l]);
            else         c = c & (x >= ofs_t[e][l]);
          end
        end
        ln[l][x] = c;
      end
    end
    for (int k = 0; k < 8; k++)
      for (int r = 0; r < 4; r++)
        for (int b = 0; b < 8; b++)
          t[32*k + 8*r + b] = ln[4*(k/4) + r][8*(k%4) + b];
    return t;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [NB-1:0] act,
                     input logic [NB-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic pack();
    for (int e = 0; e < NE; e++) begin
      edge_en[e]    = en_t[e];
      edge_right[e] = rt_t[e];
      for (int l = 0; l < NL; l++)
        edge_ofs[(e*NL + l)*OW +: OW] = OW'(ofs_t[e][l]);
    end
  endtask

  task automatic run(input string req);
    logic [NB-1:0] exp;
    @(negedge clk);
    pack();
    in_valid = 1'b1;
    exp = model();
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid === 1'b1 && tile_mask === exp, req, tile_mask, exp);
    last_exp = exp;
  endtask

  task automatic clear_edges();
    for (int e = 0; e < NE; e++) begin
      en_t[e] = 1'b0; rt_t[e] = 1'b0;
      for (int l = 0; l < NL; l++) ofs_t[e][l] = 0;
    end
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog expired act=hang exp=finish");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; edge_en = '0; edge_right = '0; edge_ofs = '0;
    clear_edges();
    repeat (3) @(negedge clk);
    chk(out_valid === 1'b0 && tile_mask === '0, "R9 reset state", tile_mask, '0);
    rst_n = 1'b1;

    // R2 R3 R4 R1 R7: single edge sweep, every lane skewed differently
    for (int e = 0; e < NE; e++)
      for (int f = 0; f < 2; f++)
        for (int base = -6; base <= 38; base++) begin
          clear_edges();
          en_t[e] = 1'b1; rt_t[e] = f[0];
          for (int l = 0; l < NL; l++) ofs_t[e][l] = base + 3*l - 10;
          run(f ? "R3 R4 R1 R7 right edge" : "R2 R4 R1 R7 left edge");
        end

    // R6: left/right pair spans
    for (int a = -2; a <= 34; a += 3)
      for (int b = -2; b <= 34; b += 3) begin
        clear_edges();
        en_t[0] = 1'b1; rt_t[0] = 1'b0;
        en_t[2] = 1'b1; rt_t[2] = 1'b1;
        for (int l = 0; l < NL; l++) begin
          ofs_t[0][l] = a + l;
          ofs_t[2][l] = b - l;
        end
        run("R6 span AND");
      end

    // R6 R5 R1: pseudo-random triangles with random enables
    void'($urandom(11));
    for (int i = 0; i < 300; i++) begin
      for (int e = 0; e < NE; e++) begin
        en_t[e] = 1'($urandom_range(0, 3) != 0);
        rt_t[e] = 1'($urandom_range(0, 1));
        for (int l = 0; l < NL; l++) ofs_t[e][l] = int'($urandom_range(0, 44)) - 6;
      end
      run("R6 R5 R1 triangle mix");
    end

    // R5: no edge enabled, garbage positions
    for (int e = 0; e < NE; e++) begin
      en_t[e] = 1'b0; rt_t[e] = 1'b1;
      for (int l = 0; l < NL; l++) ofs_t[e][l] = 17 - 5*l;
    end
    run("R5 all edges disabled");
    chk(&tile_mask, "R5 all ones", tile_mask, '1);

    // R8: idle cycle with changed data leaves the output untouched
    @(negedge clk);
    for (int e = 0; e < NE; e++) begin
      en_t[e] = 1'b1; rt_t[e] = 1'b0;
      for (int l = 0; l < NL; l++) ofs_t[e][l] = 40;
    end
    pack();
    in_valid = 1'b0;
    @(negedge clk);
    chk(out_valid === 1'b0, "R8 valid low when idle", {255'd0, out_valid}, '0);
    chk(tile_mask === last_exp, "R8 hold when idle", tile_mask, last_exp);
    @(negedge clk);
    chk(tile_mask === last_exp, "R8 still held", tile_mask, last_exp);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule